// File: doc/BRIEF.md
# Branch Map Checkpoint Store

This block keeps whole-table copies of the speculative register rename map, one copy per unresolved branch. When a branch dispatches, the front end offers the current map; the store takes it into a free slot and returns that slot's number. The number travels with the branch. When the branch resolves, execution reports the slot number with either a correct or a mispredict verdict.

A correct verdict releases that slot alone. A mispredict causes the map captured for that branch to come back out one cycle later, so the rename stage can reload it at once, long before the branch retires. All checkpoints taken after the resolving one are released in the same step and listed in a squash mask. Other recovery logic (free list repair, scheduler squash) uses that mask. Age is tracked by allocation order, not by slot number, so slots can be reused in any order.

Top module: `ckpt_map_store`

## Requirements
- R1: After reset no checkpoint is in use: `snap_ready` is 1, `snap_id` is 0, `restore_valid` is 0 and `squash_mask` is 0.
- R2: A `snap_req` while a slot is free and no mispredict is presented raises `snap_grant` in the same cycle. `snap_id` names the lowest-numbered free slot, and that slot is in use from the next cycle.
- R3: When all `CKPT_DEPTH` slots are in use, `snap_ready` is 0 and a `snap_req` is not granted.
- R4: A correct resolution of an in-use slot releases that slot only. Every other in-use slot stays in use.
- R5: A mispredict on an in-use slot sets `restore_valid` for exactly one cycle, starting one cycle later. At that time `restore_map` equals the map captured when that slot was granted.
- R6: With `restore_valid`, `squash_mask` bit i is 1 exactly when slot i was in use and was granted after the resolving slot; the resolving slot's own bit is 0. Without `restore_valid`, the mask is 0.
- R7: A mispredict releases the resolving slot and every younger slot. Slots granted before it stay in use.
- R8: A `snap_req` in the same cycle as `bad_valid` is not granted, whether or not the mispredict names an in-use slot.
- R9: A correct or mispredict resolution naming a slot that is not in use has no effect: no restore, no mask and no release.
- R10: Age follows grant order, not slot number: a reused low-numbered slot counts as younger than higher-numbered slots granted before it.
- R11: A correct resolution and a mispredict in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snap_req | input | 1 | Branch dispatch asks for a checkpoint |
| snap_map | input | ARCH_REGS*TAG_W | Current speculative map; entry r is in bits [r*TAG_W +: TAG_W] |
| snap_ready | output | 1 | At least one slot is free |
| snap_grant | output | 1 | Request accepted this cycle |
| snap_id | output | $clog2(CKPT_DEPTH) | Slot granted, which is the lowest free slot |
| ok_valid | input | 1 | Branch resolved as predicted |
| ok_id | input | $clog2(CKPT_DEPTH) | Slot of the correctly predicted branch |
| bad_valid | input | 1 | Branch resolved as mispredicted |
| bad_id | input | $clog2(CKPT_DEPTH) | Slot of the mispredicted branch |
| restore_valid | output | 1 | Restored map is presented |
| restore_map | output | ARCH_REGS*TAG_W | Map captured when the mispredicted branch dispatched |
| squash_mask | output | CKPT_DEPTH | Slots younger than the mispredicted branch, now released |

## Verification
The bench builds the block with its defaults: four slots, eight architectural registers and 6-bit tags. With four slots, filling and draining the store takes a handful of cycles. Random release patterns then quickly leave slots reused out of numeric order, which is where age tracking by grant order can disagree with slot number. A 48-bit map carries a distinct random pattern per snapshot, so a restore from the wrong slot cannot go unnoticed.

// File: rtl/ckpt_pkg.sv
// Package: shared defaults and the resolution classification used by the
// checkpoint store. Assumes nothing beyond IEEE 1800-2017.
package ckpt_pkg;
    localparam int CKPT_DEPTH_DEF = 4;
    localparam int ARCH_REGS_DEF  = 8;
    localparam int TAG_W_DEF      = 6;

    // Which resolution verdicts hit an in-use slot this cycle
    typedef enum logic [1:0] {
        RSV_IDLE = 2'b00,
        RSV_KEEP = 2'b01,
        RSV_UNDO = 2'b10,
        RSV_BOTH = 2'b11
    } resolve_kind_e;
endpackage

// File: rtl/ckpt_free_pick.sv
// Free slot finder: reports whether any slot is free and names the
// lowest-numbered one. Assumes DEPTH >= 2. Purely combinational.
module ckpt_free_pick #(
    parameter int DEPTH = 4,
    localparam int ID_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] busy,
    output logic             any_free,
    output logic [ID_W-1:0]  pick_id
);
    // Scan from the top down so the lowest free index wins
    always_comb begin
        any_free = 1'b0;
        pick_id  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                pick_id  = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/ckpt_age_matrix.sv
// Age matrix: row i, bit j is set when slot i was granted before slot j.
// On a grant of slot k, column k takes the current busy vector and row k
// is cleared. Stale bits in rows of free slots are masked by busy on read.
// Assumes at most one grant per cycle.
module ckpt_age_matrix #(
    parameter int DEPTH = 4,
    localparam int ID_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] busy,
    input  logic             alloc_en,
    input  logic [ID_W-1:0]  alloc_id,
    input  logic [ID_W-1:0]  query_id,
    output logic [DEPTH-1:0] younger_mask
);
    logic [DEPTH-1:0] older_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        // Update one row: clear it for the new slot, else mark age vs new slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                older_q[i] <= '0;
            end else if (alloc_en) begin
                if (alloc_id == ID_W'(i)) begin
                    older_q[i] <= '0;
                end else begin
                    older_q[i][alloc_id] <= busy[i];
                end
            end
        end
    end

    // Slots granted after the queried slot and still in use
    always_comb begin
        younger_mask = older_q[query_id] & busy;
    end
endmodule

// File: rtl/ckpt_snap_bank.sv
// Snapshot bank: one map-wide register per slot, written on grant and
// read by slot number. Assumes a single writer per cycle.
module ckpt_snap_bank #(
    parameter int DEPTH = 4,
    parameter int MAP_W = 48,
    localparam int ID_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  wr_id,
    input  logic [MAP_W-1:0] wr_map,
    input  logic [ID_W-1:0]  rd_id,
    output logic [MAP_W-1:0] rd_map
);
    logic [MAP_W-1:0] slot_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Capture the offered map when this slot is granted
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (wr_en && wr_id == ID_W'(s)) begin
                slot_q[s] <= wr_map;
            end
        end
    end

    // Read port for restore
    always_comb begin
        rd_map = slot_q[rd_id];
    end
endmodule

// File: rtl/ckpt_map_store.sv
// Branch map checkpoint store (top). Grants the lowest free slot to a
// dispatching branch and captures its map. A correct resolution frees
// one slot. A mispredict frees the slot and all younger ones, and one
// cycle later presents the saved map and the younger-slot mask.
// Assumes ids arriving with ok_valid/bad_valid are in range.
module ckpt_map_store #(
    parameter int CKPT_DEPTH = ckpt_pkg::CKPT_DEPTH_DEF,
    parameter int ARCH_REGS  = ckpt_pkg::ARCH_REGS_DEF,
    parameter int TAG_W      = ckpt_pkg::TAG_W_DEF,
    localparam int ID_W  = $clog2(CKPT_DEPTH),
    localparam int MAP_W = ARCH_REGS * TAG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  snap_req,
    input  logic [MAP_W-1:0]      snap_map,
    output logic                  snap_ready,
    output logic                  snap_grant,
    output logic [ID_W-1:0]       snap_id,
    input  logic                  ok_valid,
    input  logic [ID_W-1:0]       ok_id,
    input  logic                  bad_valid,
    input  logic [ID_W-1:0]       bad_id,
    output logic                  restore_valid,
    output logic [MAP_W-1:0]      restore_map,
    output logic [CKPT_DEPTH-1:0] squash_mask
);
    import ckpt_pkg::*;

    logic [CKPT_DEPTH-1:0] busy_q;
    logic [CKPT_DEPTH-1:0] busy_d;
    logic [CKPT_DEPTH-1:0] younger;
    logic [CKPT_DEPTH-1:0] release_mask;
    logic [CKPT_DEPTH-1:0] grant_mask;
    logic [MAP_W-1:0]      saved_map;
    logic                  any_free;
    logic [ID_W-1:0]       free_id;
    logic                  ok_hit;
    logic                  bad_hit;
    resolve_kind_e         kind;

    ckpt_free_pick #(.DEPTH(CKPT_DEPTH)) u_pick (
        .busy     (busy_q),
        .any_free (any_free),
        .pick_id  (free_id)
    );

    ckpt_age_matrix #(.DEPTH(CKPT_DEPTH)) u_age (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy_q),
        .alloc_en     (snap_grant),
        .alloc_id     (free_id),
        .query_id     (bad_id),
        .younger_mask (younger)
    );

    ckpt_snap_bank #(.DEPTH(CKPT_DEPTH), .MAP_W(MAP_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (snap_grant),
        .wr_id  (free_id),
        .wr_map (snap_map),
        .rd_id  (bad_id),
        .rd_map (saved_map)
    );

    // Dispatch handshake: a mispredict in flight blocks wrong-path grants
    always_comb begin
        snap_ready = any_free;
        snap_id    = free_id;
        snap_grant = snap_req && any_free && !bad_valid;
        grant_mask = snap_grant ? (CKPT_DEPTH'(1) << free_id) : '0;
    end

    // Classify resolutions that name an in-use slot
    always_comb begin
        ok_hit  = ok_valid && busy_q[ok_id];
        bad_hit = bad_valid && busy_q[bad_id];
        kind    = resolve_kind_e'({bad_hit, ok_hit});
    end

    // Build the set of slots freed this cycle
    always_comb begin
        unique case (kind)
            RSV_KEEP: release_mask = CKPT_DEPTH'(1) << ok_id;
            RSV_UNDO: release_mask = (CKPT_DEPTH'(1) << bad_id) | younger;
            RSV_BOTH: release_mask = (CKPT_DEPTH'(1) << ok_id)
                                   | (CKPT_DEPTH'(1) << bad_id) | younger;
            default:  release_mask = '0;
        endcase
        busy_d = (busy_q & ~release_mask) | grant_mask;
    end

    // Occupancy register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= busy_d;
        end
    end

    // Restore outputs, one cycle after a mispredict that hits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restore_valid <= 1'b0;
            restore_map   <= '0;
            squash_mask   <= '0;
        end else begin
            restore_valid <= bad_hit;
            squash_mask   <= bad_hit ? younger : '0;
            if (bad_hit) begin
                restore_map <= saved_map;
            end
        end
    end
endmodule

// File: rtl/ckpt_map_store_chk.sv
// Assertion checker for ckpt_map_store, attached by bind. Observes the
// ports and the occupancy register; drives nothing.
module ckpt_map_store_chk #(
    parameter int CKPT_DEPTH = 4,
    localparam int ID_W = $clog2(CKPT_DEPTH)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  snap_req,
    input logic                  snap_ready,
    input logic                  snap_grant,
    input logic                  bad_valid,
    input logic [ID_W-1:0]       bad_id,
    input logic                  restore_valid,
    input logic [CKPT_DEPTH-1:0] squash_mask,
    input logic [CKPT_DEPTH-1:0] busy_q
);
    AST_NO_GRANT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_ready |-> !snap_grant); // R3
    AST_READY_TRACKS_OCCUPANCY: assert property (@(posedge clk) disable iff (!rst_n)
        snap_ready == ($countones(busy_q) != CKPT_DEPTH)); // R3
    AST_GRANT_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        snap_grant |-> snap_req); // R2
    AST_NO_GRANT_ON_MISPREDICT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_valid |-> !snap_grant); // R8
    AST_RESTORE_AFTER_MISPREDICT: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> $past(bad_valid)); // R5
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_valid |-> squash_mask == '0); // R6
    AST_MASK_EXCLUDES_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> !squash_mask[$past(bad_id)]); // R6
    AST_SQUASHED_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> (squash_mask & busy_q) == '0); // R7
endmodule

bind ckpt_map_store ckpt_map_store_chk #(.CKPT_DEPTH(CKPT_DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .snap_req      (snap_req),
    .snap_ready    (snap_ready),
    .snap_grant    (snap_grant),
    .bad_valid     (bad_valid),
    .bad_id        (bad_id),
    .restore_valid (restore_valid),
    .squash_mask   (squash_mask),
    .busy_q        (busy_q)
);

// File: tb/tb_ckpt_map_store.sv
// Bench: directed scenarios plus a random phase, compared every cycle
// against a behavioural model (slot flags, grant-order queue, map array).
module tb_ckpt_map_store;
    localparam int N  = 4;
    localparam int AR = 8;
    localparam int TW = 6;
    localparam int MW = AR * TW;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          snap_req;
    logic [MW-1:0] snap_map;
    logic          snap_ready;
    logic          snap_grant;
    logic [IW-1:0] snap_id;
    logic          ok_valid;
    logic [IW-1:0] ok_id;
    logic          bad_valid;
    logic [IW-1:0] bad_id;
    logic          restore_valid;
    logic [MW-1:0] restore_map;
    logic [N-1:0]  squash_mask;

    always #5 clk = ~clk;

    ckpt_map_store dut (
        .clk(clk), .rst_n(rst_n), .snap_req(snap_req), .snap_map(snap_map),
        .snap_ready(snap_ready), .snap_grant(snap_grant), .snap_id(snap_id),
        .ok_valid(ok_valid), .ok_id(ok_id), .bad_valid(bad_valid), .bad_id(bad_id),
        .restore_valid(restore_valid), .restore_map(restore_map),
        .squash_mask(squash_mask)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model
    bit            m_busy [N];
    int            m_order [$];
    logic [MW-1:0] m_map [N];
    logic          e_rv;
    logic [MW-1:0] e_map;
    logic [N-1:0]  e_mask;
    logic [MW-1:0] saved0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < N; i++) c += m_busy[i];
        return c;
    endfunction

    function automatic int m_low_free();
        for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
        return N;
    endfunction

    function automatic logic [MW-1:0] rmap();
        return {$urandom, $urandom};
    endfunction

    // Drive inputs at the falling edge and compare every output
    task automatic drive(input logic rq, input logic [MW-1:0] mp,
                         input logic ov, input int oi, input logic bv, input int bi);
        @(negedge clk);
        snap_req = rq; snap_map = mp;
        ok_valid = ov; ok_id = IW'(oi);
        bad_valid = bv; bad_id = IW'(bi);
        #1;
        chk("R3 snap_ready", snap_ready, m_count() < N);
        if (m_count() < N) chk("R2 snap_id", snap_id, m_low_free());
        chk("R2/R8 snap_grant", snap_grant, rq && m_count() < N && !bv);
        chk("R5 restore_valid", restore_valid, e_rv);
        if (e_rv) chk("R5 restore_map", restore_map, e_map);
        chk("R6 squash_mask", squash_mask, e_mask);
    endtask

    // Advance the model across the rising edge
    task automatic edge_step();
        int  lf;
        bit  g;
        int  p;
        lf = m_low_free();
        g  = snap_req && m_count() < N && !bad_valid;
        @(posedge clk);
        e_rv = 1'b0; e_mask = '0;
        if (bad_valid && m_busy[bad_id]) begin
            e_rv = 1'b1; e_map = m_map[bad_id];
            p = 0;
            for (int k = 0; k < m_order.size(); k++) if (m_order[k] == int'(bad_id)) p = k;
            for (int k = p + 1; k < m_order.size(); k++) e_mask[m_order[k]] = 1'b1;
            while (m_order.size() > p) begin
                m_busy[m_order[m_order.size() - 1]] = 0;
                void'(m_order.pop_back());
            end
        end
        if (ok_valid && m_busy[ok_id]) begin
            m_busy[ok_id] = 0;
            for (int k = 0; k < m_order.size(); k++)
                if (m_order[k] == int'(ok_id)) begin m_order.delete(k); break; end
        end
        if (g) begin
            m_busy[lf] = 1; m_order.push_back(lf); m_map[lf] = snap_map;
        end
    endtask

    task automatic cyc(input logic rq, input logic [MW-1:0] mp,
                       input logic ov, input int oi, input logic bv, input int bi);
        drive(rq, mp, ov, oi, bv, bi);
        edge_step();
    endtask

    task automatic idle_peek();
        drive(0, '0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; snap_req = 0; snap_map = '0; ok_valid = 0; ok_id = '0;
        bad_valid = 0; bad_id = '0;
        for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_map[i] = '0; end
        e_rv = 0; e_map = '0; e_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state
        idle_peek();
        chk("R1 snap_ready", snap_ready, 1);
        chk("R1 snap_id", snap_id, 0);
        chk("R1 restore_valid", restore_valid, 0);
        chk("R1 squash_mask", squash_mask, 0);
        edge_step();

        // R2/R3: fill all slots, then a request is refused
        saved0 = rmap();
        cyc(1, saved0, 0, 0, 0, 0);
        for (int i = 1; i < N; i++) cyc(1, rmap(), 0, 0, 0, 0);
        drive(1, rmap(), 0, 0, 0, 0);
        chk("R3 full refuses", snap_grant, 0);
        edge_step();

        // R4: correct resolution on slot 1 frees only slot 1
        cyc(0, '0, 1, 1, 0, 0);
        idle_peek();
        chk("R4 freed slot", snap_id, 1);
        edge_step();
        cyc(1, rmap(), 0, 0, 0, 0);
        idle_peek();
        chk("R4 others kept", snap_ready, 0);
        edge_step();

        // R10/R5/R6: mispredict on slot 0; grant order 0,2,3,1
        cyc(0, '0, 0, 0, 1, 0);
        idle_peek();
        chk("R10 squash order", squash_mask, 4'b1110);
        chk("R5 slot0 map", restore_map, saved0);
        chk("R7 all freed", snap_id, 0);
        edge_step();

        // R7: refill 0..3, mispredict on slot 2 keeps 0 and 1
        for (int i = 0; i < N; i++) cyc(1, rmap(), 0, 0, 0, 0);
        cyc(0, '0, 0, 0, 1, 2);
        idle_peek();
        chk("R7 younger mask", squash_mask, 4'b1000);
        chk("R7 lowest free", snap_id, 2);
        edge_step();
        cyc(1, rmap(), 0, 0, 0, 0);
        cyc(1, rmap(), 0, 0, 0, 0);
        idle_peek();
        chk("R7 older kept", snap_ready, 0);
        edge_step();

        // R9: resolutions on a free slot are ignored
        cyc(0, '0, 1, 3, 0, 0);
        cyc(0, '0, 1, 3, 1, 3);
        idle_peek();
        chk("R9 no restore", restore_valid, 0);
        chk("R9 no release", snap_id, 3);
        edge_step();
        cyc(0, '0, 0, 0, 0, 0);

        // R8: request alongside a mispredict is not granted
        drive(1, rmap(), 0, 0, 1, 1);
        chk("R8 blocked", snap_grant, 0);
        edge_step();
        idle_peek();
        chk("R8 mask", squash_mask, 4'b0100);
        edge_step();

        // R11: correct on slot 0 and mispredict on slot 1 together
        cyc(1, rmap(), 0, 0, 0, 0);
        cyc(0, '0, 1, 0, 1, 1);
        idle_peek();
        chk("R11 restore", restore_valid, 1);
        chk("R11 both freed", snap_id, 0);
        edge_step();

        // Random phase against the model
        for (int i = 0; i < 800; i++) begin
            cyc(($urandom % 3) != 0, rmap(),
                ($urandom % 4) == 0, $urandom % N,
                ($urandom % 7) == 0, $urandom % N);
        end
        idle_peek();
        edge_step();

        done = 1;
        summary();
        $finish;
    end
endmodule